// File: doc/BRIEF.md
# Load-Balanced Switch Output Resequencer

This block sits at one output port of a two-stage load-balanced switch. Each source input spreads its consecutive cells over the centre-stage buffers in strict rotation, so cell k of a source travels through centre stage (k mod N). The centre stages drain at different rates, so the cells of one source can reach this output out of order. Each arriving cell carries its source index and the index of the centre stage it came through. The block parks the cell in a slot addressed by that (source, centre) pair and releases the cells of every source in their original order.

Ordering is restored without sequence numbers. For every source the block keeps one pointer: the centre stage whose cell must leave next. When that cell is present, the source index joins a first-in first-out departure queue. The head of the queue names the source that leaves next, and its pointer names the slot to read. When a cell leaves, the pointer of its source advances by one, modulo N. If the following cell is already waiting, the source index is put back into the queue in the same cycle. Each arrival and each departure costs a fixed amount of work that does not depend on N. A source whose expected cell is missing holds all of its later cells, even if they are present. If a departing source is re-queued in the same cycle that a different source becomes eligible, the departing source is written into the queue first.

Both data edges use valid/ready. On the input side a transfer happens when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` depends only on the presented `in_src`/`in_ctr` pair: it is low while that slot still holds a cell. A source that drives a blocked slot must hold its cell until the slot frees up. On the output side `out_valid` stays high and `out_src`/`out_data` stay constant until `out_ready` accepts the cell. At most one cell enters and one cell leaves per cycle.

Top module: `lbr_reseq`

## Requirements
- R1: After reset `out_valid` is 0, every slot is empty (so `in_ready` is 1 for any pair), and every source expects centre stage 0 first.
- R2: `in_ready` is 0 while the slot for the presented (`in_src`, `in_ctr`) pair is occupied. A cell offered while `in_ready` is 0 is not stored and never appears at the output.
- R3: When the cell a source expects is accepted, the source is eligible from the next cycle: with an empty queue, `out_valid` is 1 one cycle after the accepting edge. Cells from later centre stages of a source whose expected cell is missing stay held, and `out_valid` remains 0 for them.
- R4: The cells of each source leave in centre-stage order: 0, 1, …, N-1, then 0 again. Arrivals in any permutation of that order still leave in that order.
- R5: When a cell leaves and the next cell of its source is already stored, that source is re-queued in the same cycle. With `out_ready` held high, a fully present run of cells leaves in consecutive cycles.
- R6: Sources leave in the order in which their expected cells became available (first-in first-out across sources).
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_src` and `out_data` unchanged.
- R8: A source index is never in the departure queue more than once, so the queue holds at most N entries. After all cells have left, `out_valid` is 0.
- R9: Each departing cell carries the exact payload it arrived with, and `out_src` equals the source it arrived from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving cell is presented |
| in_ready | output | 1 | Slot for the presented pair is free |
| in_src | input | IDX_W | Source input of the arriving cell |
| in_ctr | input | IDX_W | Centre stage the cell came through |
| in_data | input | DATA_W | Cell payload |
| out_valid | output | 1 | A cell is ready to leave in order |
| out_ready | input | 1 | Downstream accepts the cell |
| out_src | output | IDX_W | Source of the departing cell |
| out_data | output | DATA_W | Payload of the departing cell |

## Verification
The properties assume a fabric that obeys the rotation: a source never sends a new cell into a (source, centre) slot before the previous cell of that pair has left. They also assume that `in_src` and `in_ctr` stay below N. The stimulus respects both rules. It sends full rounds of N cells per source, each round in a random permutation, and a driver blocks on `in_ready` whenever it offers a slot that the previous round has not yet drained. Directed phases add an early cell held back by a missing predecessor, a refused offer to a full slot, a stalled output, and a reversed run of arrivals that must leave back to back.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned LBR_PORTS_DFLT = 4;
  localparam int unsigned LBR_DATA_DFLT  = 16;

  // Flat slot number of a (source, centre) pair; slots of one source are contiguous.
  function automatic int slot_index(input int src, input int ctr, input int n);
    return src * n + ctr;
  endfunction
endpackage

// File: rtl/lbr_slot_store.sv
module lbr_slot_store #(
  parameter int unsigned N_PORTS = lbr_pkg::LBR_PORTS_DFLT,
  parameter int unsigned DATA_W  = lbr_pkg::LBR_DATA_DFLT,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned SLOTS  = N_PORTS * N_PORTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_src,
  input  logic [IDX_W-1:0]  wr_ctr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_src,
  input  logic [IDX_W-1:0]  clr_ctr,
  input  logic [IDX_W-1:0]  rd_src,
  input  logic [IDX_W-1:0]  rd_ctr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  occ
);
  logic [DATA_W-1:0] cell_mem [SLOTS];
  logic [SLOT_W-1:0] wr_idx, clr_idx, rd_idx;

  assign wr_idx  = SLOT_W'(lbr_pkg::slot_index(int'(wr_src),  int'(wr_ctr),  N_PORTS));
  assign clr_idx = SLOT_W'(lbr_pkg::slot_index(int'(clr_src), int'(clr_ctr), N_PORTS));
  assign rd_idx  = SLOT_W'(lbr_pkg::slot_index(int'(rd_src),  int'(rd_ctr),  N_PORTS));

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[g] <= 1'b0;
      end else if (wr_en && wr_idx == SLOT_W'(g)) begin
        occ[g] <= 1'b1;
      end else if (clr_en && clr_idx == SLOT_W'(g)) begin
        occ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == SLOT_W'(g)) cell_mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < SLOTS) rd_data = cell_mem[rd_idx];
  end
endmodule

// File: rtl/lbr_flow_ptrs.sv
module lbr_flow_ptrs #(
  parameter int unsigned N_PORTS = lbr_pkg::LBR_PORTS_DFLT,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv_en,
  input  logic [IDX_W-1:0]                adv_src,
  output logic [N_PORTS-1:0][IDX_W-1:0]   ptr
);
  // One rotation pointer per source: the centre stage whose cell leaves next.
  for (genvar g = 0; g < N_PORTS; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr[g] <= '0;
      end else if (adv_en && adv_src == IDX_W'(g)) begin
        ptr[g] <= (ptr[g] == IDX_W'(N_PORTS - 1)) ? '0 : ptr[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbr_depart_fifo.sv
module lbr_depart_fifo #(
  parameter int unsigned DEPTH   = lbr_pkg::LBR_PORTS_DFLT,
  parameter int unsigned WIDTH   = 2,
  localparam int unsigned PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [WIDTH-1:0] data_a,
  input  logic             push_b,
  input  logic [WIDTH-1:0] data_b,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] q_mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr, wr_p1, wr_p2;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_p1 = bump(wr_ptr);
  assign wr_p2 = bump(wr_p1);
  assign head  = q_mem[rd_ptr];
  assign empty = (count == '0);

  // Port A is written ahead of port B when both push in one cycle.
  always_ff @(posedge clk) begin
    if (push_a) q_mem[wr_ptr] <= data_a;
    if (push_b) q_mem[push_a ? wr_p1 : wr_ptr] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push_a, push_b})
        2'b11:        wr_ptr <= wr_p2;
        2'b10, 2'b01: wr_ptr <= wr_p1;
        default:      wr_ptr <= wr_ptr;
      endcase
      count <= count + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/lbr_reseq.sv
module lbr_reseq #(
  parameter int unsigned N_PORTS = lbr_pkg::LBR_PORTS_DFLT,
  parameter int unsigned DATA_W  = lbr_pkg::LBR_DATA_DFLT,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned SLOTS  = N_PORTS * N_PORTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(N_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_src,
  input  logic [IDX_W-1:0]  in_ctr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_src,
  output logic [DATA_W-1:0] out_data
);
  logic                          fire_in, fire_out;
  logic [SLOTS-1:0]              slot_occ;
  logic [N_PORTS-1:0][IDX_W-1:0] exp_ptr;
  logic [IDX_W-1:0]              dep_src, dep_ctr, nxt_ctr;
  logic [SLOT_W-1:0]             in_idx, nxt_idx;
  logic                          q_empty;
  logic [CNT_W-1:0]              q_cnt;
  logic                          re_push, arr_push;

  assign in_idx   = SLOT_W'(lbr_pkg::slot_index(int'(in_src), int'(in_ctr), N_PORTS));
  assign in_ready = !slot_occ[in_idx];
  assign fire_in  = in_valid && in_ready;

  assign out_valid = !q_empty;
  assign fire_out  = out_valid && out_ready;
  assign out_src   = dep_src;

  assign dep_ctr = exp_ptr[dep_src];
  assign nxt_ctr = (dep_ctr == IDX_W'(N_PORTS - 1)) ? '0 : dep_ctr + 1'b1;
  assign nxt_idx = SLOT_W'(lbr_pkg::slot_index(int'(dep_src), int'(nxt_ctr), N_PORTS));

  // Departing source goes back in line if its next cell is stored or lands now.
  assign re_push = fire_out &&
                   (slot_occ[nxt_idx] ||
                    (fire_in && in_src == dep_src && in_ctr == nxt_ctr));

  // An arrival makes its source eligible when it is the expected cell;
  // the departing source is handled by re_push instead.
  assign arr_push = fire_in && (in_ctr == exp_ptr[in_src]) &&
                    !(fire_out && in_src == dep_src);

  lbr_slot_store #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire_in),
    .wr_src  (in_src),
    .wr_ctr  (in_ctr),
    .wr_data (in_data),
    .clr_en  (fire_out),
    .clr_src (dep_src),
    .clr_ctr (dep_ctr),
    .rd_src  (dep_src),
    .rd_ctr  (dep_ctr),
    .rd_data (out_data),
    .occ     (slot_occ)
  );

  lbr_flow_ptrs #(.N_PORTS(N_PORTS)) ptrs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (fire_out),
    .adv_src (dep_src),
    .ptr     (exp_ptr)
  );

  lbr_depart_fifo #(.DEPTH(N_PORTS), .WIDTH(IDX_W)) queue_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (re_push),
    .data_a (dep_src),
    .push_b (arr_push),
    .data_b (in_src),
    .pop    (fire_out),
    .head   (dep_src),
    .empty  (q_empty),
    .count  (q_cnt)
  );
endmodule

// File: rtl/lbr_reseq_chk.sv
module lbr_reseq_chk #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned SLOTS  = N_PORTS * N_PORTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(N_PORTS + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [IDX_W-1:0]              in_src,
  input logic [IDX_W-1:0]              in_ctr,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [IDX_W-1:0]              out_src,
  input logic [DATA_W-1:0]             out_data,
  input logic [CNT_W-1:0]              q_cnt,
  input logic [N_PORTS-1:0][IDX_W-1:0] exp_ptr,
  input logic [SLOTS-1:0]              occ
);
  logic [IDX_W-1:0]  head_ctr, head_next;
  logic [SLOT_W-1:0] head_idx;

  assign head_ctr  = exp_ptr[out_src];
  assign head_next = (head_ctr == IDX_W'(N_PORTS - 1)) ? '0 : head_ctr + 1'b1;
  assign head_idx  = SLOT_W'(lbr_pkg::slot_index(int'(out_src), int'(head_ctr), N_PORTS));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && q_cnt == '0));

  assert_full_slot_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 (in_src == $past(in_src) && in_ctr == $past(in_ctr))
    |-> !in_ready);

  assert_head_cell_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ[head_idx]);

  assert_pointer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> exp_ptr[$past(out_src)] == $past(head_next));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
    (out_valid && $stable(out_src) && $stable(out_data)));

  assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(N_PORTS));
endmodule

bind lbr_reseq lbr_reseq_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_src    (in_src),
  .in_ctr    (in_ctr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_src   (out_src),
  .out_data  (out_data),
  .q_cnt     (q_cnt),
  .exp_ptr   (exp_ptr),
  .occ       (slot_occ)
);

// File: tb/lbr_reseq_tb_top.sv
`timescale 1ns/1ps
module lbr_reseq_tb_top;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int ROUNDS = 6;
  localparam int WD_LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [IW-1:0] in_src = '0;
  logic [IW-1:0] in_ctr = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [IW-1:0] out_src;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rdy_mode = 0;  // 0: stall, 1: always ready, 2: random

  logic [DW-1:0] sb_q [N][$];
  int            log_src [$];
  int            log_cyc [$];
  logic [DW-1:0] log_dat [$];

  always #4 clk = ~clk;

  lbr_reseq #(.N_PORTS(N), .DATA_W(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_src    (in_src),
    .in_ctr    (in_ctr),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_src   (out_src),
    .out_data  (out_data)
  );

  function automatic logic [DW-1:0] mk(input int r, input int s, input int c);
    return {8'(r), 4'(s), 4'(c)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int s, input int c, input logic [DW-1:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_src = IW'(s); in_ctr = IW'(c); in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b0;
      1:       out_ready = 1'b1;
      default: out_ready = ($urandom % 4) != 0;
    endcase
  end

  // Monitor: pops the scoreboard on every accepted departure.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_valid && out_ready) begin
      log_src.push_back(int'(out_src));
      log_cyc.push_back(cyc);
      log_dat.push_back(out_data);
      chk(out_data[7:4] == 4'(out_src), "R9 source tag", 32'(out_data), 32'(out_src));
      if (sb_q[out_src].size() == 0) begin
        chk(1'b0, "R9 unexpected departure", 32'(out_data), 32'h0);
      end else begin
        logic [DW-1:0] e;
        e = sb_q[out_src].pop_front();
        chk(out_data == e, "R4 per-source order", 32'(out_data), 32'(e));
      end
    end
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base [N];
    int ps [N*N];
    int pc [N*N];

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

    // Phase A: held early cell, refused offer, stall, FIFO order.
    sb_q[1].push_back(mk(8'hA0, 1, 0));
    sb_q[1].push_back(mk(8'hA0, 1, 1));
    sb_q[2].push_back(mk(8'hA0, 2, 0));
    send(1, 1, mk(8'hA0, 1, 1));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R3 early cell held", 32'(out_valid), 32'h0);

    @(posedge clk); #1;
    in_valid = 1'b1; in_src = 2'd1; in_ctr = 2'd1; in_data = 16'hDEAD;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 occupied slot refuses", 32'(in_ready), 32'h0);
    @(posedge clk); #1;
    in_valid = 1'b0;

    send(1, 0, mk(8'hA0, 1, 0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R3 expected cell eligible", 32'(out_valid), 32'h1);
    chk(out_src == 2'd1, "R3 head source", 32'(out_src), 32'h1);
    send(2, 0, mk(8'hA0, 2, 0));
    @(negedge clk);
    chk(out_valid && out_data == mk(8'hA0, 1, 0), "R7 stalled output held",
        32'(out_data), 32'(mk(8'hA0, 1, 0)));
    chk(out_src == 2'd1, "R7 stalled source held", 32'(out_src), 32'h1);

    rdy_mode = 1;
    repeat (12) @(negedge clk);
    chk(log_src.size() == 3, "R6 departures in phase A", 32'(log_src.size()), 32'd3);
    if (log_src.size() >= 3) begin
      chk(log_src[0] == 1 && log_src[1] == 2 && log_src[2] == 1, "R6 FIFO order",
          32'({log_src[0][3:0], log_src[1][3:0], log_src[2][3:0]}), 32'h121);
      chk(log_dat[2] == mk(8'hA0, 1, 1), "R5 re-queued source", 32'(log_dat[2]),
          32'(mk(8'hA0, 1, 1)));
    end

    // Phase A2: reversed run must leave back to back once complete.
    for (int c = 0; c < N; c++) sb_q[3].push_back(mk(8'hB0, 3, c));
    for (int c = N - 1; c >= 0; c--) send(3, c, mk(8'hB0, 3, c));
    repeat (10) @(negedge clk);
    chk(log_src.size() == 3 + N, "R5 run departures", 32'(log_src.size()), 32'(3 + N));
    if (log_src.size() == 3 + N) begin
      for (int k = 3; k < 3 + N - 1; k++)
        chk(log_cyc[k+1] == log_cyc[k] + 1, "R5 consecutive cycles",
            32'(log_cyc[k+1] - log_cyc[k]), 32'h1);
    end

    // Phase B: permuted rounds under random back-pressure, pointers wrap.
    base[0] = 0; base[1] = 2; base[2] = 1; base[3] = 0;
    rdy_mode = 2;
    for (int r = 0; r < ROUNDS; r++) begin
      for (int s = 0; s < N; s++)
        for (int k = 0; k < N; k++) begin
          sb_q[s].push_back(mk(r, s, (base[s] + k) % N));
          ps[s*N + k] = s;
          pc[s*N + k] = (base[s] + k) % N;
        end
      for (int i = N*N - 1; i > 0; i--) begin
        int j;
        int t;
        j = int'($urandom_range(i, 0));
        t = ps[i]; ps[i] = ps[j]; ps[j] = t;
        t = pc[i]; pc[i] = pc[j]; pc[j] = t;
      end
      for (int i = 0; i < N*N; i++) send(ps[i], pc[i], mk(r, ps[i], pc[i]));
    end
    rdy_mode = 1;
    repeat (40) @(negedge clk);
    for (int s = 0; s < N; s++)
      chk(sb_q[s].size() == 0, "R4 all cells delivered", 32'(sb_q[s].size()), 32'h0);
    chk(out_valid == 1'b0, "R8 queue empty after drain", 32'(out_valid), 32'h0);
    chk(log_src.size() == 3 + N + ROUNDS*N*N, "R9 departure count",
        32'(log_src.size()), 32'(3 + N + ROUNDS*N*N));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule